// File: doc/BRIEF.md
# Serial Memory Array Access Engine

This block carries out array reads and array writes for a serial byte-wide memory once the interface front-end has decoded the command byte and collected both address bytes. It holds a 2048-byte register-file array. A read streams bytes out of a free-running address counter. A write gathers incoming bytes into a 32-byte page buffer and then commits them to the array in one self-timed write cycle. While that cycle runs, a busy flag is raised.

The front-end gives one `cmdStart` pulse per command. It asks for each outgoing read byte with `rdNext` and delivers each incoming write byte with `wrValid`. When chip-select rises it pulses `csRise`, and `byteAligned` tells whether the bit count at that moment was a whole number of bytes. The status block decides whether a write may go ahead and passes that decision in as `cmdAccept`.

Top module: `memArrayEngine`

## Requirements
- R1: After reset, every array byte reads as 0x00, and `busy` and `rdValid` are both 0.
- R2: The command address is 16 bits wide. Only bits 10:0 select a byte, so bits 15:11 have no effect on reads or writes.
- R3: After an accepted read command, each `rdNext` pulse produces `rdValid`=1 on the next cycle, with `rdData` equal to the byte at the current address. The address then increments, and after 0x7FF it wraps to 0x000.
- R4: A `cmdStart` that arrives while `busy`=1 is refused. No `rdNext` pulse then yields `rdValid`, either during the busy period or after it, until a new command is accepted.
- R5: A write command with `cmdAccept`=0 is refused. Its bytes never reach the array and it never raises `busy`.
- R6: Write bytes land at successive offsets inside the 32-byte page selected by address bits 10:5. The offset is address bits 4:0, and it wraps from 31 back to 0 within the same page. A later byte written to the same offset replaces the earlier one.
- R7: A `csRise` during an accepted write raises `busy` on the next cycle only when `byteAligned`=1 and at least one byte was received. Otherwise no write cycle starts and the array is unchanged.
- R8: `busy` stays 1 for exactly `WRITE_CYCLES` cycles. The buffered bytes are visible in the array once it falls.
- R9: Only the page offsets that received a byte are committed. Every other location in the page keeps its previous contents.
- R10: An aborted write discards its buffered bytes, so none of them appear in the array after a later committed write to the same page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdStart | input | 1 | Command decoded and address complete (one-cycle pulse) |
| cmdIsWrite | input | 1 | 1 for an array write, 0 for an array read |
| cmdAccept | input | 1 | Write permitted by the protection logic |
| cmdAddr | input | 16 | Two address bytes; bits 10:0 significant |
| rdNext | input | 1 | Request for the next read byte |
| wrValid | input | 1 | Write data byte present on `wrByte` |
| wrByte | input | 8 | Write data byte |
| csRise | input | 1 | Chip-select has risen; the command ends |
| byteAligned | input | 1 | Clock count at `csRise` is a multiple of eight |
| rdData | output | 8 | Read byte |
| rdValid | output | 1 | `rdData` holds a new byte this cycle |
| busy | output | 1 | Self-timed write cycle in progress |

## Verification
A read byte appears one cycle after its `rdNext` edge. The bench pulses the request on a falling edge and checks `rdValid` and `rdData` on the next falling edge, after the single capturing register. `busy` goes high one cycle after the `csRise` edge and stays high for `WRITE_CYCLES` cycles. The bench therefore samples it on the first falling edge after the pulse and counts falling edges until it drops. Array contents are checked only after `busy` has fallen, by reading them back through a fresh read command.

// File: rtl/memEnginePkg.sv
package memEnginePkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_COLLECT,
    ST_BUSY
  } engState_t;

  typedef struct packed {
    logic loadAddr;
    logic rdStep;
    logic wrStore;
    logic clearBuf;
    logic commit;
  } engStrobe_t;
endpackage

// File: rtl/memEngineCtrl.sv
module memEngineCtrl
  import memEnginePkg::*;
#(
  parameter int WRITE_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdStart,
  input  logic       cmdIsWrite,
  input  logic       cmdAccept,
  input  logic       rdNext,
  input  logic       wrValid,
  input  logic       csRise,
  input  logic       byteAligned,
  input  logic       bufHasData,
  output engStrobe_t stb,
  output logic       busy
);
  localparam int TW = $clog2(WRITE_CYCLES + 1);

  engState_t state, nextState;
  logic [TW-1:0] timerCnt;
  logic timerDone;

  assign timerDone = (timerCnt == TW'(WRITE_CYCLES - 1));

  always_comb begin
    stb = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (cmdStart) begin
          if (!cmdIsWrite) begin
            stb.loadAddr = 1'b1;
            nextState = ST_READ;
          end else if (cmdAccept) begin
            stb.loadAddr = 1'b1;
            nextState = ST_COLLECT;
          end
        end
      end
      ST_READ: begin
        stb.rdStep = rdNext;
        if (csRise) nextState = ST_IDLE;
      end
      ST_COLLECT: begin
        stb.wrStore = wrValid;
        if (csRise) begin
          if (byteAligned && bufHasData) begin
            nextState = ST_BUSY;
          end else begin
            stb.clearBuf = 1'b1;
            nextState = ST_IDLE;
          end
        end
      end
      ST_BUSY: begin
        if (timerDone) begin
          stb.commit = 1'b1;
          stb.clearBuf = 1'b1;
          nextState = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      timerCnt <= '0;
    end else begin
      state <= nextState;
      if (state == ST_BUSY) timerCnt <= timerCnt + 1'b1;
      else timerCnt <= '0;
    end
  end

  assign busy = (state == ST_BUSY);
endmodule

// File: rtl/memEngineDatapath.sv
module memEngineDatapath
  import memEnginePkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int PAGE_W     = 5,
  parameter int DATA_W     = 8,
  parameter int CMD_ADDR_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  engStrobe_t            stb,
  input  logic [CMD_ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0]     wrByte,
  output logic [DATA_W-1:0]     rdData,
  output logic                  rdValid,
  output logic                  bufHasData
);
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int BASE_W     = ADDR_W - PAGE_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] rdPtr;
  logic [BASE_W-1:0] pageBase;
  logic [PAGE_W-1:0] wrOff;
  logic [DATA_W-1:0] laneData [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] laneValid;

  logic unusedHi;
  assign unusedHi = ^cmdAddr[CMD_ADDR_W-1:ADDR_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr <= '0;
      pageBase <= '0;
      wrOff <= '0;
    end else if (stb.loadAddr) begin
      rdPtr <= cmdAddr[ADDR_W-1:0];
      pageBase <= cmdAddr[ADDR_W-1:PAGE_W];
      wrOff <= cmdAddr[PAGE_W-1:0];
    end else begin
      if (stb.rdStep) rdPtr <= rdPtr + 1'b1;
      if (stb.wrStore) wrOff <= wrOff + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData <= '0;
    end else begin
      rdValid <= stb.rdStep;
      if (stb.rdStep) rdData <= mem[rdPtr];
    end
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : gLane
    always_ff @(posedge clk) begin
      if (!rstN || stb.clearBuf) begin
        laneValid[g] <= 1'b0;
        laneData[g] <= '0;
      end else if (stb.wrStore && (wrOff == PAGE_W'(g))) begin
        laneValid[g] <= 1'b1;
        laneData[g] <= wrByte;
      end
    end
  end

  assign bufHasData = |laneValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (stb.commit) begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (laneValid[i]) mem[{pageBase, PAGE_W'(i)}] <= laneData[i];
      end
    end
  end
endmodule

// File: rtl/memArrayEngine.sv
module memArrayEngine
  import memEnginePkg::*;
#(
  parameter int ADDR_W       = 11,
  parameter int PAGE_W       = 5,
  parameter int DATA_W       = 8,
  parameter int CMD_ADDR_W   = 16,
  parameter int WRITE_CYCLES = 1000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cmdStart,
  input  logic                  cmdIsWrite,
  input  logic                  cmdAccept,
  input  logic [CMD_ADDR_W-1:0] cmdAddr,
  input  logic                  rdNext,
  input  logic                  wrValid,
  input  logic [DATA_W-1:0]     wrByte,
  input  logic                  csRise,
  input  logic                  byteAligned,
  output logic [DATA_W-1:0]     rdData,
  output logic                  rdValid,
  output logic                  busy
);
  engStrobe_t stb;
  logic bufHasData;

  memEngineCtrl #(.WRITE_CYCLES(WRITE_CYCLES)) ctrl (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .cmdIsWrite(cmdIsWrite),
    .cmdAccept(cmdAccept), .rdNext(rdNext), .wrValid(wrValid), .csRise(csRise),
    .byteAligned(byteAligned), .bufHasData(bufHasData), .stb(stb), .busy(busy)
  );

  memEngineDatapath #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W), .CMD_ADDR_W(CMD_ADDR_W)
  ) dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cmdAddr(cmdAddr), .wrByte(wrByte),
    .rdData(rdData), .rdValid(rdValid), .bufHasData(bufHasData)
  );
endmodule

// File: rtl/memArrayEngineChk.sv
module memArrayEngineChk #(
  parameter int WRITE_CYCLES = 1000
) (
  input logic clk,
  input logic rstN,
  input logic rdNext,
  input logic rdValid,
  input logic csRise,
  input logic busy
);
  localparam int CW = $clog2(WRITE_CYCLES + 2);
  logic [CW-1:0] busyLen;

  always_ff @(posedge clk) begin
    if (!rstN) busyLen <= '0;
    else if (busy) busyLen <= busyLen + 1'b1;
    else busyLen <= '0;
  end

  p_valid_needs_req_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdValid) |-> $past(rdNext));

  p_no_read_while_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && rdNext) |=> !rdValid);

  p_busy_after_rise_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(csRise));

  p_busy_length_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyLen == CW'(WRITE_CYCLES)));
endmodule

bind memArrayEngine memArrayEngineChk #(.WRITE_CYCLES(WRITE_CYCLES)) chk (
  .clk(clk), .rstN(rstN), .rdNext(rdNext), .rdValid(rdValid),
  .csRise(csRise), .busy(busy)
);

// File: tb/memArrayEngine_test.sv
`timescale 1ns/1ps
module memArrayEngine_test;
  localparam int WC = 24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdStart = 1'b0, cmdIsWrite = 1'b0, cmdAccept = 1'b0;
  logic [15:0] cmdAddr = '0;
  logic rdNext = 1'b0, wrValid = 1'b0, csRise = 1'b0, byteAligned = 1'b0;
  logic [7:0] wrByte = '0;
  logic [7:0] rdData;
  logic rdValid, busy;

  int checks = 0;
  int errors = 0;

  logic [7:0] mMem [2048];
  logic [7:0] pBuf [32];
  logic [31:0] pVal;
  logic [5:0] mBase;
  logic [4:0] mOff;
  logic [10:0] mPtr;
  bit mWrite, mRead;

  always #2.5 clk = ~clk;

  memArrayEngine #(.WRITE_CYCLES(WC)) uut (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .cmdIsWrite(cmdIsWrite),
    .cmdAccept(cmdAccept), .cmdAddr(cmdAddr), .rdNext(rdNext), .wrValid(wrValid),
    .wrByte(wrByte), .csRise(csRise), .byteAligned(byteAligned),
    .rdData(rdData), .rdValid(rdValid), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic startCmd(input bit isW, input logic [15:0] a, input bit acc);
    @(negedge clk);
    cmdStart = 1'b1; cmdIsWrite = isW; cmdAccept = acc; cmdAddr = a;
    @(negedge clk);
    cmdStart = 1'b0;
    mWrite = isW && acc;
    mRead = !isW;
    mPtr = a[10:0];
    mBase = a[10:5];
    mOff = a[4:0];
    pVal = '0;
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    wrValid = 1'b1; wrByte = b;
    @(negedge clk);
    wrValid = 1'b0;
    if (mWrite) begin
      pBuf[mOff] = b;
      pVal[mOff] = 1'b1;
      mOff = mOff + 1'b1;
    end
  endtask

  task automatic readBytes(input int n, input string req);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      rdNext = 1'b1;
      @(negedge clk);
      rdNext = 1'b0;
      check(rdValid === 1'b1, req, int'(rdValid), 1);
      check(rdData === mMem[mPtr], req, int'(rdData), int'(mMem[mPtr]));
      mPtr = mPtr + 1'b1;
    end
  endtask

  task automatic endCmd(input bit aligned, input string req);
    bit expBusy;
    int cnt;
    expBusy = mWrite && aligned && (pVal != '0);
    @(negedge clk);
    csRise = 1'b1; byteAligned = aligned;
    @(negedge clk);
    csRise = 1'b0; byteAligned = 1'b0;
    check(busy === expBusy, req, int'(busy), int'(expBusy));
    if (expBusy) begin
      cnt = 0;
      while (busy === 1'b1 && cnt < 10 * WC) begin
        cnt++;
        @(negedge clk);
      end
      check(cnt == WC, "R8 busy length", cnt, WC);
      for (int i = 0; i < 32; i++)
        if (pVal[i]) mMem[{mBase, i[4:0]}] = pBuf[i];
    end
    mWrite = 1'b0;
    mRead = 1'b0;
    pVal = '0;
  endtask

  task automatic readBack(input logic [15:0] a, input int n, input string req);
    startCmd(1'b0, a, 1'b0);
    readBytes(n, req);
    endCmd(1'b1, req);
  endtask

  initial begin
    #750000;
    errors++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] refused;
    for (int i = 0; i < 2048; i++) mMem[i] = 8'h00;
    pVal = '0; mWrite = 0; mRead = 0; mPtr = '0; mBase = '0; mOff = '0;
    void'($urandom(32'd1357));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(busy === 1'b0, "R1 busy after reset", int'(busy), 0);
    check(rdValid === 1'b0, "R1 rdValid after reset", int'(rdValid), 0);
    readBack(16'h0000, 3, "R1 zero array");

    // R3: read wraps from the top of the array to address 0
    startCmd(1'b1, 16'h07E0, 1'b1);
    sendByte(8'hA1); sendByte(8'hA2);
    endCmd(1'b1, "R7 commit start");
    startCmd(1'b1, 16'h0000, 1'b1);
    sendByte(8'h5C);
    endCmd(1'b1, "R7 commit start");
    readBack(16'h07FE, 4, "R3 read wrap");

    // R2: upper address bits ignored
    startCmd(1'b1, 16'hF805, 1'b1);
    sendByte(8'h3E);
    endCmd(1'b1, "R2 write high bits");
    readBack(16'h0004, 3, "R2 read low address");
    readBack(16'hA805, 1, "R2 read high bits");

    // R6: page roll-over and overwrite of a repeated offset
    startCmd(1'b1, 16'h013E, 1'b1);
    for (int k = 0; k < 36; k++) sendByte(8'(8'h40 + k));
    endCmd(1'b1, "R6 page roll");
    readBack(16'h0120, 32, "R6 page contents");
    readBack(16'h0140, 1, "R6 next page untouched");

    // R9: only received offsets committed
    startCmd(1'b1, 16'h0124, 1'b1);
    sendByte(8'hEE);
    endCmd(1'b1, "R9 single byte");
    readBack(16'h0122, 5, "R9 neighbours kept");

    // R7: unaligned rise and rise with no data start no cycle
    startCmd(1'b1, 16'h0200, 1'b1);
    sendByte(8'h77);
    endCmd(1'b0, "R7 unaligned abort");
    startCmd(1'b1, 16'h0210, 1'b1);
    endCmd(1'b1, "R7 no data");
    readBack(16'h0200, 1, "R7 array unchanged");

    // R10: aborted bytes do not leak into a later commit
    startCmd(1'b1, 16'h0203, 1'b1);
    sendByte(8'h99);
    endCmd(1'b0, "R10 abort");
    startCmd(1'b1, 16'h0204, 1'b1);
    sendByte(8'h12);
    endCmd(1'b1, "R10 later write");
    readBack(16'h0203, 2, "R10 no leak");

    // R5: refused write
    startCmd(1'b1, 16'h0300, 1'b0);
    sendByte(8'hDD);
    endCmd(1'b1, "R5 refused write no busy");
    readBack(16'h0300, 1, "R5 array unchanged");

    // R4: read refused while busy
    startCmd(1'b1, 16'h0400, 1'b1);
    sendByte(8'h61);
    for (int i = 0; i < 32; i++) if (pVal[i]) mMem[{mBase, i[4:0]}] = pBuf[i];
    @(negedge clk);
    csRise = 1'b1; byteAligned = 1'b1;
    @(negedge clk);
    csRise = 1'b0; byteAligned = 1'b0;
    check(busy === 1'b1, "R4 busy for probe", int'(busy), 1);
    @(negedge clk);
    cmdStart = 1'b1; cmdIsWrite = 1'b0; cmdAddr = 16'h0400;
    @(negedge clk);
    cmdStart = 1'b0;
    @(negedge clk);
    rdNext = 1'b1;
    @(negedge clk);
    rdNext = 1'b0;
    check(rdValid === 1'b0, "R4 no byte while busy", int'(rdValid), 0);
    while (busy === 1'b1) @(negedge clk);
    @(negedge clk);
    rdNext = 1'b1;
    @(negedge clk);
    rdNext = 1'b0;
    check(rdValid === 1'b0, "R4 refused command stays dead", int'(rdValid), 0);
    mWrite = 0; pVal = '0;
    readBack(16'h0400, 1, "R4 write still committed");

    // Random mix
    for (int it = 0; it < 40; it++) begin
      logic [15:0] a;
      a = 16'($urandom);
      if ($urandom % 2 == 0) begin
        int n;
        bit acc, al;
        n = 1 + int'($urandom % 40);
        acc = ($urandom % 5) != 0;
        al = ($urandom % 5) != 0;
        startCmd(1'b1, a, acc);
        for (int k = 0; k < n; k++) sendByte(8'($urandom));
        endCmd(al, "R6 random write");
      end else begin
        refused = 8'(1 + $urandom % 6);
        readBack(a, int'(refused), "R3 random read");
      end
    end
    readBack(16'h0000, 64, "R9 final sweep");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule